// File: doc/BRIEF.md
# Clock Fan-out Buffer Configuration Slave

This block is a two-wire serial slave that holds the setup registers of a two-bank differential clock fan-out buffer. It turns those registers into per-output control signals: one enable for each differential pair and each feedback output, skew codes for every output group, and slew codes for every pair. SCL and SDA come in as plain inputs. The data line is driven open-drain through a single pull-low enable.

A host reaches the registers in two ways. Byte transactions address one register at a time. Block transactions always start at index 0 and walk the whole 24-entry index space. Two board-level pins gate the pair enables: one gates the even-numbered pairs and the other gates the odd-numbered pairs. The feedback enables follow their register bits alone. Delay lines, drivers and analog timing are not part of this block, so the codes are only exported as fields.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD4 (write) or 0xD5 (read), i.e. 7-bit address 0x6A. Any other address gets a NACK, and the rest of that transaction leaves every register unchanged.
- R2: In a write, a command byte with bit 7 set selects byte mode, and bits 6:0 give the register index. The following data byte is stored at that index, and every byte of an addressed write is acknowledged.
- R3: After a byte-mode command, a repeated START with 0xD5 returns the register at the selected index.
- R4: A command byte with bit 7 clear selects block mode, which starts at index 0. The next byte written is a byte count and is discarded. Each later data byte goes to the next index in turn.
- R5: A block-mode read returns the count 24 first, followed by the contents of indices 0 to 23 in order.
- R6: Reset values are: index 6 = FFh, index 7 = FFh, index 18 = 88h, index 19 = 80h, index 20 = 8Ah, indices 21 to 23 = AAh. All other indices, including those of 24 and above, always read 00h, and writes to them are dropped.
- R7: Bits 5:0 of index 6 and index 7 are the pair enables of bank A and bank B. Bit 6 of each is that bank's feedback enable. A pair k output is high only when its bit is 1 and the even pin is high (k even) or the odd pin is high (k odd). The pins do not gate the feedback enables.
- R8: Skew fields are mapped as follows. Bank A true = index 18 [6:4]. Bank A complement = index 18 [2:0]. Bank B complement = index 19 [6:4]. Bank A input = index 19 [3:2]. Bank B input = index 19 [1:0]. Bank B true = index 20 [6:4].
- R9: Slew fields are mapped as follows. Bank A pair k is 2-bit field k, counted from the MSB, of the 12-bit word {index 20 [3:0], index 21}. Bank B pair k is field k, counted from the MSB, of {index 22, index 23 [7:4]}. Feedback B = index 23 [3:2] and feedback A = index 23 [1:0].
- R10: START or STOP (an SDA edge while SCL is high) returns the slave to address reception, or to idle, with SDA released. A master NACK after a read byte ends the transfer with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when 1 |
| even_en_i | input | 1 | Gate for pairs 0, 2 and 4, active high |
| odd_en_i | input | 1 | Gate for pairs 1, 3 and 5, active high |
| pair_en_a | output | 6 | Bank A pair enables |
| pair_en_b | output | 6 | Bank B pair enables |
| fb_en_a | output | 1 | Bank A feedback enable |
| fb_en_b | output | 1 | Bank B feedback enable |
| skew_true_a | output | 3 | Bank A true-output skew code |
| skew_comp_a | output | 3 | Bank A complement-output skew code |
| skew_true_b | output | 3 | Bank B true-output skew code |
| skew_comp_b | output | 3 | Bank B complement-output skew code |
| skew_in_a | output | 2 | Bank A input-to-feedback skew code |
| skew_in_b | output | 2 | Bank B input-to-feedback skew code |
| slew_a | output | 12 | Bank A pair slew codes, pair k at [2k+1:2k] |
| slew_b | output | 12 | Bank B pair slew codes, pair k at [2k+1:2k] |
| slew_fb_a | output | 2 | Bank A feedback slew code |
| slew_fb_b | output | 2 | Bank B feedback slew code |

## Verification
Some rules hold on every cycle and are checked continuously. SDA is never pulled in idle. A START always re-arms address reception. Transmission happens only in a read. A register changes only on an SCL fall during a write. A low pin always masks its pairs. The bench scenarios cover what only a whole transaction can show. These are the byte and field mappings, the reset contents, block ordering with the leading count, a foreign address being ignored, and aborted or out-of-range writes having no effect. All of these are read back through the serial port or seen on the field outputs.

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         NREG     = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        even_en_i,
  input  logic        odd_en_i,
  output logic [5:0]  pair_en_a,
  output logic [5:0]  pair_en_b,
  output logic        fb_en_a,
  output logic        fb_en_b,
  output logic [2:0]  skew_true_a,
  output logic [2:0]  skew_comp_a,
  output logic [2:0]  skew_true_b,
  output logic [2:0]  skew_comp_b,
  output logic [1:0]  skew_in_a,
  output logic [1:0]  skew_in_b,
  output logic [11:0] slew_a,
  output logic [11:0] slew_b,
  output logic [1:0]  slew_fb_a,
  output logic [1:0]  slew_fb_b
);
  localparam logic [7:0] COUNT = 8'(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;

  function automatic logic [3:0] slot_of(input logic [7:0] i);
    if (i == 8'd6 || i == 8'd7) return {1'b1, 3'(i - 8'd6)};
    if (i >= 8'd18 && i <= 8'd23) return {1'b1, 3'(i - 8'd16)};
    return 4'd0;
  endfunction

  function automatic logic [7:0] rst_val(input int k);
    case (k)
      0, 1:    return 8'hFF;
      2:       return 8'h88;
      3:       return 8'h80;
      4:       return 8'h8A;
      default: return 8'hAA;
    endcase
  endfunction

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start    = scl_p[1] & scl_p[2] & ~sda_p[1] & sda_p[2];
  wire stop     = scl_p[1] & scl_p[2] & sda_p[1] & ~sda_p[2];

  st_t        st;
  logic [3:0] bc;
  logic [1:0] bn;
  logic [7:0] sh, tx, idx;
  logic       rw, cnt_pend;
  logic [7:0] regs [0:7];

  logic [3:0] hit;
  assign hit = slot_of(idx);
  wire [7:0] rd_data = hit[3] ? regs[hit[2:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bc <= '0; bn <= '0; sh <= '0; tx <= '0; idx <= '0;
      rw <= 1'b0; cnt_pend <= 1'b0; sda_oe <= 1'b0;
      for (int k = 0; k < 8; k++) regs[k] <= rst_val(k);
    end else if (start) begin
      st <= S_RX; bc <= '0; bn <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (scl_rise) begin
      if (st == S_RX && bc != 4'd8) begin
        sh <= {sh[6:0], sda_p[1]};
        bc <= bc + 4'd1;
      end else if (st == S_TACK && sda_p[1]) begin
        st <= S_IDLE;
      end
    end else if (scl_fall) begin
      case (st)
        S_RX: if (bc == 4'd8) begin
          if (bn != 2'd2) bn <= bn + 2'd1;
          if (bn == 2'd0) begin
            if (sh[7:1] == DEV_ADDR) begin
              rw <= sh[0]; sda_oe <= 1'b1; st <= S_RACK;
            end else st <= S_IDLE;
          end else begin
            sda_oe <= 1'b1; st <= S_RACK;
            if (bn == 2'd1) begin
              cnt_pend <= ~sh[7];
              idx      <= sh[7] ? {1'b0, sh[6:0]} : 8'd0;
            end else if (cnt_pend) cnt_pend <= 1'b0;
            else begin
              if (hit[3]) regs[hit[2:0]] <= sh;
              idx <= idx + 8'd1;
            end
          end
        end
        S_RACK, S_TACK: begin
          bc <= (st == S_TACK || rw) ? 4'd1 : 4'd0;
          if (st == S_RACK && !rw) begin
            sda_oe <= 1'b0; st <= S_RX;
          end else begin
            st <= S_TX;
            if (cnt_pend) begin
              tx <= COUNT; sda_oe <= ~COUNT[7]; cnt_pend <= 1'b0;
            end else begin
              tx <= rd_data; sda_oe <= ~rd_data[7]; idx <= idx + 8'd1;
            end
          end
        end
        S_TX: if (bc == 4'd8) begin
          sda_oe <= 1'b0; st <= S_TACK;
        end else begin
          tx <= tx << 1; sda_oe <= ~tx[6]; bc <= bc + 4'd1;
        end
        default: ;
      endcase
    end

  wire [5:0] pin_mask = {3{odd_en_i, even_en_i}};
  assign pair_en_a   = regs[0][5:0] & pin_mask;
  assign pair_en_b   = regs[1][5:0] & pin_mask;
  assign fb_en_a     = regs[0][6];
  assign fb_en_b     = regs[1][6];
  assign skew_true_a = regs[2][6:4];
  assign skew_comp_a = regs[2][2:0];
  assign skew_comp_b = regs[3][6:4];
  assign skew_in_a   = regs[3][3:2];
  assign skew_in_b   = regs[3][1:0];
  assign skew_true_b = regs[4][6:4];
  assign slew_a      = {regs[5][1:0], regs[5][3:2], regs[5][5:4], regs[5][7:6],
                        regs[4][1:0], regs[4][3:2]};
  assign slew_b      = {regs[7][5:4], regs[7][7:6], regs[6][1:0], regs[6][3:2],
                        regs[6][5:4], regs[6][7:6]};
  assign slew_fb_b   = regs[7][3:2];
  assign slew_fb_a   = regs[7][1:0];

  wire [63:0] live_flat = {regs[7], regs[6], regs[5], regs[4],
                           regs[3], regs[2], regs[1], regs[0]};

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);
  p_start_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == S_RX && !sda_oe));
  p_tx_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_TX |-> rw);
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_RACK |-> sda_oe);
  p_write_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_flat) |-> ($past(st) == S_RX && !$past(rw) && $past(scl_fall)));
  p_even_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !even_en_i |-> ((pair_en_a & 6'b010101) == 6'd0 && (pair_en_b & 6'b010101) == 6'd0));
  p_odd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_en_i |-> ((pair_en_a & 6'b101010) == 6'd0 && (pair_en_b & 6'b101010) == 6'd0));
endmodule

// File: tb/clkbuf_cfg_slave_tb.sv
module clkbuf_cfg_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic even_en = 1'b1, odd_en = 1'b1;
  logic sda_oe, sda_line;
  logic [5:0] pair_en_a, pair_en_b;
  logic fb_en_a, fb_en_b;
  logic [2:0] skew_true_a, skew_comp_a, skew_true_b, skew_comp_b;
  logic [1:0] skew_in_a, skew_in_b, slew_fb_a, slew_fb_b;
  logic [11:0] slew_a, slew_b;

  assign sda_line = ~(m_low | sda_oe);

  always #2.5 clk = ~clk;

  clkbuf_cfg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .even_en_i(even_en), .odd_en_i(odd_en),
    .pair_en_a(pair_en_a), .pair_en_b(pair_en_b), .fb_en_a(fb_en_a), .fb_en_b(fb_en_b),
    .skew_true_a(skew_true_a), .skew_comp_a(skew_comp_a),
    .skew_true_b(skew_true_b), .skew_comp_b(skew_comp_b),
    .skew_in_a(skew_in_a), .skew_in_b(skew_in_b),
    .slew_a(slew_a), .slew_b(slew_b), .slew_fb_a(slew_fb_a), .slew_fb_b(slew_fb_b)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] model [0:23];
  logic [7:0] got [0:24];

  function automatic logic [7:0] exp_rst(input int i);
    case (i)
      6, 7:       return 8'hFF;
      18:         return 8'h88;
      19:         return 8'h80;
      20:         return 8'h8A;
      21, 22, 23: return 8'hAA;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic bit is_live(input int i);
    return (i == 6 || i == 7 || (i >= 18 && i <= 23));
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic hq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; hq(Q); scl = 1'b1; hq(Q); m_low = 1'b1; hq(Q); scl = 1'b0; hq(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; hq(Q); scl = 1'b1; hq(Q); m_low = 1'b0; hq(Q);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; hq(Q); scl = 1'b1; hq(2 * Q); scl = 1'b0; hq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_low = 1'b0; hq(Q); scl = 1'b1; hq(Q); ack = sda_line; hq(Q); scl = 1'b0; hq(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; hq(Q); scl = 1'b1; hq(Q); b[i] = sda_line; hq(Q); scl = 1'b0;
    end
    hq(Q); m_low = give_ack; hq(Q); scl = 1'b1; hq(2 * Q); scl = 1'b0; hq(Q); m_low = 1'b0;
  endtask

  task automatic byte_write(input int idx, input logic [7:0] d);
    logic a;
    i2c_start();
    wr_byte(8'hD4, a); check("R1 own write address ACK", a, 0);
    wr_byte(8'h80 | 8'(idx), a); check("R2 command ACK", a, 0);
    wr_byte(d, a); check("R2 data ACK", a, 0);
    i2c_stop();
  endtask

  task automatic byte_read(input int idx, output logic [7:0] d);
    logic a;
    i2c_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h80 | 8'(idx), a);
    i2c_start();
    wr_byte(8'hD5, a); check("R1 own read address ACK", a, 0);
    rd_byte(1'b0, d);
    check("R10 SDA released after master NACK", sda_oe, 0);
    i2c_stop();
  endtask

  task automatic block_read();
    logic a;
    i2c_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h00, a);
    i2c_start();
    wr_byte(8'hD5, a);
    for (int i = 0; i < 25; i++) rd_byte(i < 24, got[i]);
    i2c_stop();
  endtask

  task automatic verify_block(input string tag);
    block_read();
    check({tag, " R5 leading count"}, got[0], 24);
    for (int i = 0; i < 24; i++) check({tag, " R5 block byte"}, got[i + 1], model[i]);
  endtask

  task automatic check_fields(input string tag);
    logic [11:0] wa, wb;
    for (int k = 0; k < 6; k++) begin
      check({tag, " R7 pair A"}, pair_en_a[k], model[6][k] & ((k % 2) ? odd_en : even_en));
      check({tag, " R7 pair B"}, pair_en_b[k], model[7][k] & ((k % 2) ? odd_en : even_en));
    end
    check({tag, " R7 fb A"}, fb_en_a, model[6][6]);
    check({tag, " R7 fb B"}, fb_en_b, model[7][6]);
    check({tag, " R8 skew true A"}, skew_true_a, model[18][6:4]);
    check({tag, " R8 skew comp A"}, skew_comp_a, model[18][2:0]);
    check({tag, " R8 skew comp B"}, skew_comp_b, model[19][6:4]);
    check({tag, " R8 skew in A"}, skew_in_a, model[19][3:2]);
    check({tag, " R8 skew in B"}, skew_in_b, model[19][1:0]);
    check({tag, " R8 skew true B"}, skew_true_b, model[20][6:4]);
    wa = {model[20][3:0], model[21]};
    wb = {model[22], model[23][7:4]};
    for (int k = 0; k < 6; k++) begin
      check({tag, " R9 slew A"}, slew_a[2 * k +: 2], wa[11 - 2 * k -: 2]);
      check({tag, " R9 slew B"}, slew_b[2 * k +: 2], wb[11 - 2 * k -: 2]);
    end
    check({tag, " R9 slew fb B"}, slew_fb_b, model[23][3:2]);
    check({tag, " R9 slew fb A"}, slew_fb_a, model[23][1:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    for (int i = 0; i < 24; i++) model[i] = exp_rst(i);
    hq(5); rst_n = 1'b1; hq(5);

    check("R10 SDA idle after reset", sda_oe, 0);
    check_fields("reset R6");

    for (int i = 0; i < 24; i++) begin
      byte_read(i, d); check("R3 R6 reset readback", d, model[i]);
    end
    byte_read(40, d); check("R6 out-of-range read", d, 0);

    for (int i = 0; i < 24; i++) begin
      byte_write(i, 8'(i * 37 + 11));
      if (is_live(i)) model[i] = 8'(i * 37 + 11);
    end
    byte_write(30, 8'h5C);
    byte_read(30, d); check("R6 write beyond range dropped", d, 0);
    check_fields("byte write");
    verify_block("after byte writes");

    for (int p = 0; p < 4; p++) begin
      even_en = p[0]; odd_en = p[1]; hq(4);
      check_fields("pin sweep");
    end
    even_en = 1'b1; odd_en = 1'b1;

    i2c_start();
    wr_byte(8'hD4, a); check("R4 block address ACK", a, 0);
    wr_byte(8'h00, a); check("R4 block command ACK", a, 0);
    wr_byte(8'd24, a); check("R4 count byte ACK", a, 0);
    for (int i = 0; i < 24; i++) begin
      wr_byte(8'(i * 91 + 5), a);
      if (is_live(i)) model[i] = 8'(i * 91 + 5);
    end
    i2c_stop();
    check_fields("block write R4");
    verify_block("after block write R4");

    i2c_start();
    wr_byte(8'hD6, a); check("R1 foreign address NACK", a, 1);
    wr_byte(8'h86, a);
    wr_byte(8'h00, a);
    i2c_stop();
    byte_read(6, d); check("R1 foreign transaction ignored", d, model[6]);

    i2c_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h86, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop();
    check("R10 SDA released after STOP", sda_oe, 0);
    byte_read(6, d); check("R10 aborted write by STOP", d, model[6]);

    i2c_start();
    wr_byte(8'hD4, a);
    wr_byte(8'h87, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    i2c_start();
    wr_byte(8'hD5, a); check("R10 repeated START re-arms address", a, 0);
    rd_byte(1'b0, d); check("R10 R3 read after aborted byte", d, model[7]);
    i2c_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule